// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block decides when each rank of a DDR2 memory must be refreshed, and hands that work to a command arbiter as per-rank refresh requests. A free-running interval timer adds one owed refresh to every rank on each expiry. The arbiter pays the debt off by granting requests. The interval is 7.8 µs while the case temperature is normal and 3.9 µs when a hot flag says the case is above 85 °C. A new temperature reading only takes effect when the timer next reloads. Each rank can postpone up to eight refreshes. At seven or more it raises an urgent flag so the arbiter can give refresh top priority.

After each granted refresh the rank is closed to commands for the refresh cycle time. The block also drives the clock-enable line for self-refresh. It lowers it on request once every rank is idle. It refuses to enter while the case is hot unless the controller reports that the faster self-refresh rate has already been programmed. It keeps each CKE level for a minimum number of clocks. On exit it holds off non-read commands for the refresh time plus 10 ns, and reads for 200 clocks. Every time in nanoseconds is a parameter, rounded up to whole clocks.

The refresh request and grant pair is a valid/ready handshake with no data. A request stays high until it is granted, because a grant in a cycle with no request is ignored. The arbiter may hold off a grant as long as it likes; back-pressure only makes the owed count grow. The count stops at its ceiling, so refreshes owed beyond eight are lost. The other pins are plain levels.

Top module: `refresh_sched`

## Requirements
- R1: Out of reset, every request and urgent bit is 0, cke_o is 1, and every bit of cmd_ok_o and rd_ok_o is 1.
- R2: With the default 10 ns clock, consecutive interval expiries are 780 cycles apart while hot_i is 0 and 390 cycles apart while hot_i is 1. The first expiry comes 780 cycles after reset is released. Each expiry adds one owed refresh to every rank.
- R3: The value of hot_i is sampled only when the interval reloads. An interval already running keeps its length, and a change of hot_i does not restart the timer.
- R4: Rank r owes a count from 0 to 8. Bit r of ref_req_o is 1 when the count is nonzero and the rank is open. Bit r of ref_urgent_o is 1 when the count is 7 or more. The count never goes above 8.
- R5: A grant on bit r while bit r of ref_req_o is 1 removes one owed refresh. A grant while the request is 0 has no effect.
- R6: After a granted refresh, bits r of cmd_ok_o and ref_req_o stay 0 for exactly 11 cycles (105 ns refresh time).
- R7: cke_o falls only while sr_req_i is 1, every rank is idle and open, and no grant is being taken. Entry is refused while hot_i is 1 and fast_sr_rate_i is 0.
- R8: Every level of cke_o lasts at least 3 cycles.
- R9: After cke_o rises, cmd_ok_o stays 0 for 12 cycles and rd_ok_o stays 0 for 200 cycles.
- R10: Leaving self-refresh clears every owed count and reloads the interval timer. The reload uses the value of hot_i at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Case temperature above 85 °C |
| fast_sr_rate_i | input | 1 | Faster self-refresh rate has been programmed |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| ref_gnt_i | input | RANKS | Arbiter grant of a refresh, one bit per rank |
| ref_req_o | output | RANKS | Refresh request, one bit per rank |
| ref_urgent_o | output | RANKS | Seven or more refreshes owed |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_ok_o | output | RANKS | Non-read commands allowed to the rank |
| rd_ok_o | output | RANKS | Read commands allowed to the rank |

## Verification
The first pattern grants rank 0 at once and never grants rank 1, for nine expiries in a row. Rank 0 then measures the interval, and rank 1 walks its owed count through the urgent threshold and into saturation; draining rank 1 afterwards tells a correct cap of eight apart from a wrapped or unbounded count. A stray grant with no request, then a single grant after the next expiry, shows whether a grant outside the handshake changes the debt. Toggling hot_i partway through an interval separates a reload-time switch from one that restarts the timer or changes the running interval. The self-refresh pattern first holds the request while the case is hot and the fast rate is not programmed, then enters and asks to exit at once, which exposes the CKE minimum, the two exit windows, the cleared debt and the restarted interval.

// File: rtl/refsch_pkg.sv
`timescale 1ns/1ps
package refsch_pkg;
  typedef enum logic {SEQ_RUN = 1'b0, SEQ_SELF = 1'b1} seq_state_e;

  // picoseconds to whole clocks, rounding up
  function automatic int ps_to_ck(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ref_tick_gen.sv
`timescale 1ns/1ps
module ref_tick_gen import refsch_pkg::*; #(
  parameter int NORM_CK = 780,
  parameter int HOT_CK  = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int TW = $clog2(max2(NORM_CK, HOT_CK) + 1);
  localparam logic [TW-1:0] NORM_LD = TW'(NORM_CK - 1);
  localparam logic [TW-1:0] HOT_LD  = TW'(HOT_CK - 1);

  logic [TW-1:0] left_q;

  assign tick_o = run_i && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           left_q <= NORM_LD;
    else if (restart_i)   left_q <= hot_i ? HOT_LD : NORM_LD;
    else if (run_i) begin
      if (left_q == '0)   left_q <= hot_i ? HOT_LD : NORM_LD;
      else                left_q <= left_q - TW'(1);
    end
  end

  // R2
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !restart_i) |=> left_q == ($past(hot_i) ? HOT_LD : NORM_LD));

  // R3
  hot_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !restart_i && left_q != '0) |=> left_q == $past(left_q) - TW'(1));
endmodule

// File: rtl/rank_ref_ctl.sv
`timescale 1ns/1ps
module rank_ref_ctl #(
  parameter int PEND_MAX  = 8,
  parameter int URGENT_AT = 7,
  parameter int RFC_CK    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  input  logic open_i,
  input  logic gnt_i,
  output logic req_o,
  output logic urgent_o,
  output logic idle_o,
  output logic take_o
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam int BW = $clog2(RFC_CK + 1);
  localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

  logic [PW-1:0] pend_q;
  logic [BW-1:0] busy_q;
  logic [PW:0]   sum;

  assign idle_o   = (busy_q == '0);
  assign req_o    = open_i && idle_o && (pend_q != '0);
  assign take_o   = gnt_i && req_o;
  assign urgent_o = (pend_q >= PW'(URGENT_AT));

  always_comb begin
    sum = {1'b0, pend_q} + (PW+1)'(tick_i) - (PW+1)'(take_o);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)        pend_q <= '0;
    else if (sum > {1'b0, CAP})   pend_q <= CAP;
    else                          pend_q <= sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              busy_q <= '0;
    else if (take_o)         busy_q <= BW'(RFC_CK);
    else if (busy_q != '0)   busy_q <= busy_q - BW'(1);
  end

  // R4
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CAP);

  // R4
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == CAP && tick_i && !take_o && !clear_i) |=> pend_q == CAP);

  // R5
  take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !tick_i && !clear_i) |=> pend_q == $past(pend_q) - PW'(1));

  // R6
  rfc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (busy_q == BW'(RFC_CK) && !req_o));
endmodule

// File: rtl/sr_seq.sv
`timescale 1ns/1ps
module sr_seq import refsch_pkg::*; #(
  parameter int CKE_MIN = 3,
  parameter int XSNR_CK = 12,
  parameter int XSRD_CK = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req_i,
  input  logic hot_i,
  input  logic fast_rate_i,
  input  logic quiet_i,
  output logic cke_o,
  output logic open_o,
  output logic rd_open_o,
  output logic run_o,
  output logic exit_o
);
  localparam int HW = $clog2(CKE_MIN + 1);
  localparam int NW = $clog2(XSNR_CK + 1);
  localparam int DW = $clog2(XSRD_CK + 1);

  seq_state_e    state_q;
  logic [HW-1:0] hold_q;
  logic [NW-1:0] nr_q;
  logic [DW-1:0] rd_q;
  logic          held, enter;

  assign held      = (hold_q >= HW'(CKE_MIN));
  assign run_o     = (state_q == SEQ_RUN);
  assign cke_o     = run_o;
  assign enter     = run_o && sr_req_i && quiet_i && held && (!hot_i || fast_rate_i);
  assign exit_o    = !run_o && !sr_req_i && held;
  assign open_o    = run_o && (nr_q == '0);
  assign rd_open_o = open_o && (rd_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      hold_q  <= HW'(CKE_MIN);
    end else if (enter) begin
      state_q <= SEQ_SELF;
      hold_q  <= HW'(1);
    end else if (exit_o) begin
      state_q <= SEQ_RUN;
      hold_q  <= HW'(1);
    end else if (!held) begin
      hold_q  <= hold_q + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nr_q <= '0;
      rd_q <= '0;
    end else if (exit_o) begin
      nr_q <= NW'(XSNR_CK);
      rd_q <= DW'(XSRD_CK);
    end else begin
      if (nr_q != '0) nr_q <= nr_q - NW'(1);
      if (rd_q != '0) rd_q <= rd_q - DW'(1);
    end
  end

  // R8
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cke_o) |-> $past(hold_q) >= HW'(CKE_MIN));

  // R7
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> $past(sr_req_i && quiet_i && (!hot_i || fast_rate_i)));

  // R9
  exit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |=> (nr_q == NW'(XSNR_CK) && rd_q == DW'(XSRD_CK) && !open_o));

  // R9
  rd_after_nr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_q != '0) |-> (rd_q != '0));
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched import refsch_pkg::*; #(
  parameter int RANKS        = 2,
  parameter int CLK_PS       = 10_000,
  parameter int REFI_NORM_PS = 7_800_000,
  parameter int REFI_HOT_PS  = 3_900_000,
  parameter int RFC_PS       = 105_000,
  parameter int XSNR_PAD_PS  = 10_000,
  parameter int XSRD_CK      = 200,
  parameter int CKE_MIN_CK   = 3,
  parameter int PEND_MAX     = 8,
  parameter int URGENT_AT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hot_i,
  input  logic             fast_sr_rate_i,
  input  logic             sr_req_i,
  input  logic [RANKS-1:0] ref_gnt_i,
  output logic [RANKS-1:0] ref_req_o,
  output logic [RANKS-1:0] ref_urgent_o,
  output logic             cke_o,
  output logic [RANKS-1:0] cmd_ok_o,
  output logic [RANKS-1:0] rd_ok_o
);
  localparam int NORM_CK = ps_to_ck(REFI_NORM_PS, CLK_PS);
  localparam int HOT_CK  = ps_to_ck(REFI_HOT_PS, CLK_PS);
  localparam int RFC_CK  = ps_to_ck(RFC_PS, CLK_PS);
  localparam int XSNR_CK = ps_to_ck(RFC_PS + XSNR_PAD_PS, CLK_PS);

  logic             tick, run, restart, open, rd_open, quiet;
  logic [RANKS-1:0] idle, take;

  assign quiet = open && (&idle) && !(|take);

  ref_tick_gen #(.NORM_CK(NORM_CK), .HOT_CK(HOT_CK)) u_tick (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .run_i(run),
    .restart_i(restart), .tick_o(tick)
  );

  sr_seq #(.CKE_MIN(CKE_MIN_CK), .XSNR_CK(XSNR_CK), .XSRD_CK(XSRD_CK)) u_seq (
    .clk(clk), .rst_n(rst_n), .sr_req_i(sr_req_i), .hot_i(hot_i),
    .fast_rate_i(fast_sr_rate_i), .quiet_i(quiet), .cke_o(cke_o),
    .open_o(open), .rd_open_o(rd_open), .run_o(run), .exit_o(restart)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    rank_ref_ctl #(.PEND_MAX(PEND_MAX), .URGENT_AT(URGENT_AT), .RFC_CK(RFC_CK)) u_rank (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(restart),
      .open_i(open), .gnt_i(ref_gnt_i[r]), .req_o(ref_req_o[r]),
      .urgent_o(ref_urgent_o[r]), .idle_o(idle[r]), .take_o(take[r])
    );
    assign cmd_ok_o[r] = open && idle[r];
    assign rd_ok_o[r]  = rd_open && idle[r];
  end
endmodule

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  localparam int R = 2;

  logic clk = 1'b0, rst_n = 1'b0, hot = 1'b0, fast = 1'b0, srq = 1'b0;
  logic [R-1:0] gnt_man = '0, auto_g = '0, gnt;
  logic [R-1:0] ref_req, ref_urg, cmd_ok, rd_ok;
  logic         cke;

  assign gnt = gnt_man | (auto_g & ref_req);

  refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .hot_i(hot), .fast_sr_rate_i(fast), .sr_req_i(srq),
    .ref_gnt_i(gnt), .ref_req_o(ref_req), .ref_urgent_o(ref_urg), .cke_o(cke),
    .cmd_ok_o(cmd_ok), .rd_ok_o(rd_ok)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise0(output int t);
    do @(negedge clk); while (!ref_req[0]);
    t = cyc;
  endtask

  // R6 run-length monitor on cmd_ok after each granted refresh
  bit mon_en = 1'b0;
  int low_run [R];
  always @(negedge clk) begin
    if (mon_en) begin
      for (int r = 0; r < R; r++) begin
        if (!cmd_ok[r]) low_run[r]++;
        else begin
          if (low_run[r] != 0) chk(low_run[r] == 11, "R6 busy window after grant", low_run[r], 11);
          low_run[r] = 0;
        end
      end
    end
  end

  initial begin
    int c0, tp, t, n, te, tc, trd;
    for (int r = 0; r < R; r++) low_run[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
    chk(ref_req == 2'b00, "R1 reset requests", ref_req, 0);
    chk(ref_urg == 2'b00, "R1 reset urgent", ref_urg, 0);
    chk(cke == 1'b1, "R1 reset cke", cke, 1);
    chk(cmd_ok == 2'b11, "R1 reset cmd_ok", cmd_ok, 3);
    chk(rd_ok == 2'b11, "R1 reset rd_ok", rd_ok, 3);

    // rank 0 granted at once, rank 1 left owing
    auto_g = 2'b01;
    mon_en = 1'b1;
    tp = c0;
    for (int k = 1; k <= 9; k++) begin
      wait_rise0(t);
      chk(t - tp == 780, "R2 normal interval", t - tp, 780);
      chk(ref_req[1] == 1'b1, "R4 rank 1 request while owing", ref_req[1], 1);
      chk(ref_urg[1] == (k >= 7), "R4 urgent threshold", ref_urg[1], int'(k >= 7));
      chk(ref_urg[0] == 1'b0, "R4 rank 0 not urgent", ref_urg[0], 0);
      tp = t;
    end

    // drain rank 1: count is capped at 8 after nine expiries
    auto_g[1] = 1'b1;
    n = 1;
    repeat (150) begin
      @(negedge clk);
      if (ref_req[1]) n++;
    end
    chk(n == 8, "R4 saturated debt drained", n, 8);
    chk(ref_urg[1] == 1'b0, "R4 urgent cleared after drain", ref_urg[1], 0);

    // R5 stray grant without request
    auto_g[1] = 1'b0;
    gnt_man[1] = 1'b1;
    n = 0;
    repeat (30) begin
      @(negedge clk);
      if (!cmd_ok[1]) n++;
    end
    gnt_man[1] = 1'b0;
    chk(n == 0, "R5 stray grant starts no refresh", n, 0);
    chk(ref_req[1] == 1'b0, "R5 no request after stray grant", ref_req[1], 0);

    wait_rise0(t);
    chk(t - tp == 780, "R2 normal interval", t - tp, 780);
    tp = t;
    auto_g[1] = 1'b1;
    n = 1;
    repeat (100) begin
      @(negedge clk);
      if (ref_req[1]) n++;
    end
    chk(n == 1, "R5 stray grant did not change debt", n, 1);

    // temperature switch partway through an interval
    hot = 1'b1;
    wait_rise0(t);
    chk(t - tp == 780, "R3 running interval keeps length", t - tp, 780);
    tp = t;
    wait_rise0(t);
    chk(t - tp == 390, "R2 hot interval", t - tp, 390);
    tp = t;
    repeat (50) @(negedge clk);
    hot = 1'b0;
    wait_rise0(t);
    chk(t - tp == 390, "R3 cool switch waits for reload", t - tp, 390);
    tp = t;
    wait_rise0(t);
    chk(t - tp == 780, "R2 normal interval restored", t - tp, 780);

    // self-refresh
    auto_g[1] = 1'b0;
    hot = 1'b1;
    wait_rise0(t);
    mon_en = 1'b0;
    chk(ref_req[1] == 1'b1, "R4 rank 1 owes before self-refresh", ref_req[1], 1);
    srq = 1'b1;
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (!cke) n++;
    end
    chk(n == 0, "R7 hot entry blocked without fast rate", n, 0);
    fast = 1'b1;
    n = 0;
    while (cke && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(cke == 1'b0, "R7 entry once allowed", cke, 0);
    srq = 1'b0;
    n = 1;
    do begin
      @(negedge clk);
      if (!cke) n++;
    end while (!cke && n < 50);
    chk(n == 3, "R8 minimum low time of cke", n, 3);
    te = cyc;
    chk(cmd_ok == 2'b00, "R9 commands held after exit", cmd_ok, 0);
    while (!cmd_ok[0] && cyc - te < 400) @(negedge clk);
    tc = cyc;
    chk(tc - te == 12, "R9 non-read exit delay", tc - te, 12);
    chk(rd_ok[0] == 1'b0, "R9 reads still held", rd_ok[0], 0);
    chk(ref_req == 2'b00, "R10 owed refreshes cleared", ref_req, 0);
    chk(ref_urg == 2'b00, "R10 urgent cleared", ref_urg, 0);
    while (!rd_ok[0] && cyc - te < 400) @(negedge clk);
    trd = cyc;
    chk(trd - te == 200, "R9 read exit delay", trd - te, 200);
    chk(ref_req[1] == 1'b0, "R10 no debt before next expiry", ref_req[1], 0);
    wait_rise0(t);
    chk(t - te == 390, "R10 interval restarted at exit", t - te, 390);
    chk(ref_req[1] == 1'b1, "R10 fresh debt after expiry", ref_req[1], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule